// File: doc/BRIEF.md
# Eight-Instruction Accumulator Processor

This block is a small 8-bit processor built around one accumulator and a unified 32-word store that holds both the program and its data. Each instruction word carries an operation in its top three bits and a direct operand address in its low five bits. A sequencer walks every instruction through seven one-cycle register-transfer steps: capture the program counter as the address, read the instruction, capture the operand address, advance the program counter, copy the accumulator into the second ALU latch, read the operand into the first ALU latch, then execute.

A program is placed in the store through a valid/ready preload port while reset is held; releasing reset starts fetching at address 0. The core runs until it executes a halt, raises its halted flag and freezes. A combinational debug port reads any store word, and the accumulator is brought out directly, so results can be inspected after the halt.

Preload back-pressure: the port's ready is high only while reset is asserted. A word is written on a rising clock edge where valid and ready are both high; valid without ready has no effect and no word is queued for later.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is asserted and after release until the first halt, halted is 0; during reset the accumulator output reads 0 and pre_ready is 1.
- R2: A preload transfer (pre_valid and pre_ready high on a clock edge) writes pre_data to the word at pre_addr; with reset low pre_ready is 0 and pre_valid changes no store word.
- R3: Opcode 000 (load) places the store word at the operand address (bits 4:0) into the accumulator.
- R4: Opcode 010 (add) places the operand plus the previous accumulator value, modulo 256, into the accumulator.
- R5: Opcode 011 (complement) places the bitwise inverse of the operand into the accumulator.
- R6: Opcode 101 shifts the operand left by one with a 0 entering bit 0; opcode 110 shifts it right by one keeping bit 7; the result goes to the accumulator.
- R7: Opcode 001 (store) writes the accumulator into the store word at the operand address; no other opcode writes the store.
- R8: Opcode 100 (branch) continues at the operand address when accumulator bit 7 is 0, and at the next word otherwise.
- R9: Opcode 111 halts: halted rises at the end of that instruction's seventh cycle and afterwards the accumulator, program counter and store stay unchanged until reset.
- R10: Every instruction takes exactly seven clock cycles, so a run of N instructions ending in the halt raises halted on the 7N-th rising edge after reset is released; the program counter wraps from 31 to 0.
- R11: The program 0x04, 0x45, 0x26, 0xFF with 24 at word 4 and 30 at word 5 halts with 54 in word 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pre_valid | input | 1 | Preload word offered |
| pre_ready | output | 1 | Preload accepted this cycle (high only in reset) |
| pre_addr | input | 5 | Preload target word |
| pre_data | input | 8 | Preload value |
| halted | output | 1 | Core has executed a halt |
| dbg_addr | input | 5 | Debug read address |
| dbg_data | output | 8 | Store word at dbg_addr |
| acc_out | output | 8 | Accumulator value |

## Verification
A wrong step counter or program counter shows first as a halt that arrives on the wrong edge, since the halt cycle is fixed at seven times the executed instruction count; a skipped or repeated step shifts it at once. A latch loaded at the wrong step or a wrong ALU function appears as a wrong accumulator or a wrong stored word, visible through acc_out and the debug port as soon as the program halts. A branch decided on the wrong sign bit changes both the instruction count, hence the halt edge, and the final values.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 3'b000,
    OP_STORE = 3'b001,
    OP_ADD   = 3'b010,
    OP_INV   = 3'b011,
    OP_BRPOS = 3'b100,
    OP_SHL   = 3'b101,
    OP_SHRA  = 3'b110,
    OP_STOP  = 3'b111
  } opcode_e;

  typedef enum logic [2:0] {
    ST_ADDR_PC  = 3'd0,
    ST_FETCH    = 3'd1,
    ST_ADDR_OPD = 3'd2,
    ST_PC_STEP  = 3'd3,
    ST_HOLD_ACC = 3'd4,
    ST_READ_OPD = 3'd5,
    ST_EXEC     = 3'd6
  } step_e;

  typedef struct packed {
    logic mar_from_pc;
    logic ir_load;
    logic mar_from_ir;
    logic pc_step;
    logic lat2_load;
    logic lat1_load;
    logic acc_load;
    logic mem_store;
    logic pc_jump;
  } ctrl_t;

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [DATA_W-1:0] pre_data,
  input  logic              run_we,
  input  logic [ADDR_W-1:0] run_addr,
  input  logic [DATA_W-1:0] run_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [DATA_W-1:0] dbg_data
);

  logic [DATA_W-1:0] words [DEPTH];

  // One write port is chosen per cycle: preload has priority (the two
  // never overlap in practice because the core is frozen in reset).
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  always_comb begin
    wr_en   = pre_we | run_we;
    wr_addr = pre_we ? pre_addr : run_addr;
    wr_data = pre_we ? pre_data : run_data;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (wr_en && (wr_addr == ADDR_W'(g)))
        words[g] <= wr_data;
    end
  end

  assign rd_data  = words[rd_addr];
  assign dbg_data = words[dbg_addr];

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  opcode_e           op,
  input  logic [DATA_W-1:0] lat1,
  input  logic [DATA_W-1:0] lat2,
  output logic [DATA_W-1:0] result
);

  always_comb begin
    unique case (op)
      OP_ADD:  result = lat1 + lat2;
      OP_INV:  result = ~lat1;
      OP_SHL:  result = {lat1[DATA_W-2:0], 1'b0};
      OP_SHRA: result = {lat1[DATA_W-1], lat1[DATA_W-1:1]};
      default: result = lat1;
    endcase
  end

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  opcode_e op,
  input  logic    acc_neg,
  output step_e   step,
  output logic    halted,
  output ctrl_t   ctrl
);

  step_e step_q;
  logic  halted_q;
  logic  halt_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q   <= ST_ADDR_PC;
      halted_q <= 1'b0;
    end else if (!halted_q) begin
      step_q <= (step_q == ST_EXEC) ? ST_ADDR_PC : step_e'(step_q + 3'd1);
      if (halt_now)
        halted_q <= 1'b1;
    end
  end

  always_comb begin
    ctrl     = '0;
    halt_now = 1'b0;
    if (!halted_q) begin
      unique case (step_q)
        ST_ADDR_PC:  ctrl.mar_from_pc = 1'b1;
        ST_FETCH:    ctrl.ir_load     = 1'b1;
        ST_ADDR_OPD: ctrl.mar_from_ir = 1'b1;
        ST_PC_STEP:  ctrl.pc_step     = 1'b1;
        ST_HOLD_ACC: ctrl.lat2_load   = 1'b1;
        ST_READ_OPD: ctrl.lat1_load   = 1'b1;
        ST_EXEC: begin
          unique case (op)
            OP_STORE: ctrl.mem_store = 1'b1;
            OP_BRPOS: ctrl.pc_jump   = !acc_neg;
            OP_STOP:  halt_now       = 1'b1;
            default:  ctrl.acc_load  = 1'b1;
          endcase
        end
        default: ;
      endcase
    end
  end

  assign step   = step_q;
  assign halted = halted_q;

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 5,
  localparam int WORD_W = OP_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pre_valid,
  output logic              pre_ready,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [WORD_W-1:0] pre_data,
  output logic              halted,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic [WORD_W-1:0] dbg_data,
  output logic [WORD_W-1:0] acc_out
);

  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [WORD_W-1:0] ir_q, lat1_q, lat2_q, acc_q;
  logic [WORD_W-1:0] mem_rd, alu_y;
  opcode_e           op;
  step_e             step_w;
  ctrl_t             ctrl;

  assign op        = opcode_e'(ir_q[WORD_W-1 -: OP_W]);
  assign pre_ready = rst;

  acc_cpu_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .acc_neg (acc_q[WORD_W-1]),
    .step    (step_w),
    .halted  (halted),
    .ctrl    (ctrl)
  );

  acc_cpu_mem #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_mem (
    .clk      (clk),
    .pre_we   (pre_valid & pre_ready),
    .pre_addr (pre_addr),
    .pre_data (pre_data),
    .run_we   (ctrl.mem_store),
    .run_addr (mar_q),
    .run_data (acc_q),
    .rd_addr  (mar_q),
    .rd_data  (mem_rd),
    .dbg_addr (dbg_addr),
    .dbg_data (dbg_data)
  );

  acc_cpu_alu #(.DATA_W(WORD_W)) u_alu (
    .op     (op),
    .lat1   (lat1_q),
    .lat2   (lat2_q),
    .result (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      mar_q  <= '0;
      ir_q   <= '0;
      lat1_q <= '0;
      lat2_q <= '0;
      acc_q  <= '0;
    end else begin
      if (ctrl.mar_from_pc) mar_q  <= pc_q;
      if (ctrl.ir_load)     ir_q   <= mem_rd;
      if (ctrl.mar_from_ir) mar_q  <= ir_q[ADDR_W-1:0];
      if (ctrl.pc_step)     pc_q   <= pc_q + ADDR_W'(1);
      if (ctrl.lat2_load)   lat2_q <= acc_q;
      if (ctrl.lat1_load)   lat1_q <= mem_rd;
      if (ctrl.acc_load)    acc_q  <= alu_y;
      if (ctrl.pc_jump)     pc_q   <= ir_q[ADDR_W-1:0];
    end
  end

  assign acc_out = acc_q;

endmodule

// File: rtl/acc_cpu_core_chk.sv
module acc_cpu_core_chk #(
  parameter int ADDR_W = 5,
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              halted,
  input logic [2:0]        step,
  input logic [ADDR_W-1:0] pc,
  input logic [WORD_W-1:0] acc,
  input logic [WORD_W-1:0] ir,
  input logic [WORD_W-1:0] lat2,
  input logic              mem_store
);

  localparam logic [2:0] EXEC = 3'd6;

  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  p_halt_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(acc) && $stable(pc) && !mem_store));

  p_step_advance_r10: assert property (@(posedge clk) disable iff (rst)
    (!halted && step != EXEC) |=> (step == $past(step) + 3'd1));

  p_step_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    (!halted && step == EXEC) |=> (step == 3'd0));

  p_pc_step_r10: assert property (@(posedge clk) disable iff (rst)
    (!halted && step == 3'd3) |=> (pc == ADDR_W'($past(pc) + ADDR_W'(1))));

  p_branch_taken_r8: assert property (@(posedge clk) disable iff (rst)
    (!halted && step == EXEC && ir[WORD_W-1 -: 3] == 3'b100 && !acc[WORD_W-1])
      |=> (pc == $past(ir[ADDR_W-1:0])));

  p_branch_kept_r8: assert property (@(posedge clk) disable iff (rst)
    (!halted && step == EXEC && ir[WORD_W-1 -: 3] == 3'b100 && acc[WORD_W-1])
      |=> $stable(pc));

  p_acc_latched_r4: assert property (@(posedge clk) disable iff (rst)
    (!halted && step == 3'd4) |=> (lat2 == $past(acc)));

  p_store_only_exec_r7: assert property (@(posedge clk) disable iff (rst)
    mem_store |-> (step == EXEC && ir[WORD_W-1 -: 3] == 3'b001));

endmodule

bind acc_cpu_core acc_cpu_core_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .halted    (halted),
  .step      (step_w),
  .pc        (pc_q),
  .acc       (acc_q),
  .ir        (ir_q),
  .lat2      (lat2_q),
  .mem_store (ctrl.mem_store)
);

// File: tb/sim_acc_cpu_core.sv
module sim_acc_cpu_core;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pre_valid = 1'b0;
  logic       pre_ready;
  logic [4:0] pre_addr = '0;
  logic [7:0] pre_data = '0;
  logic       halted;
  logic [4:0] dbg_addr = '0;
  logic [7:0] dbg_data;
  logic [7:0] acc_out;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0] img  [32];
  logic [7:0] emem [32];
  logic [7:0] eacc;
  int         ecount;

  always #4 clk = ~clk;

  acc_cpu_core u0 (
    .clk(clk), .rst(rst), .pre_valid(pre_valid), .pre_ready(pre_ready),
    .pre_addr(pre_addr), .pre_data(pre_data), .halted(halted),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data), .acc_out(acc_out)
  );

  function automatic logic [7:0] enc(input logic [2:0] op, input logic [4:0] a);
    return {op, a};
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  // Instruction-level model of the requirements R3..R10
  task automatic run_model();
    logic [4:0] pc;
    logic [7:0] w, opd;
    for (int i = 0; i < 32; i++) emem[i] = img[i];
    pc = '0; eacc = '0; ecount = 0;
    while (ecount < 200) begin
      w = emem[pc];
      pc = pc + 5'd1;
      opd = emem[w[4:0]];
      ecount++;
      case (w[7:5])
        3'b000: eacc = opd;
        3'b001: emem[w[4:0]] = eacc;
        3'b010: eacc = opd + eacc;
        3'b011: eacc = ~opd;
        3'b100: if (!eacc[7]) pc = w[4:0];
        3'b101: eacc = {opd[6:0], 1'b0};
        3'b110: eacc = {opd[7], opd[7:1]};
        default: break;
      endcase
    end
  endtask

  task automatic load_and_run(input string tag);
    int cyc;
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 32; i++) begin
      pre_valid = 1'b1; pre_addr = 5'(i); pre_data = img[i];
      @(negedge clk);
    end
    pre_valid = 1'b0;
    @(negedge clk);
    chk({tag, " R1 halted in reset"}, int'(halted), 0);
    chk({tag, " R1 acc in reset"}, int'(acc_out), 0);
    run_model();
    rst = 1'b0;
    cyc = 0;
    while (cyc < 7 * ecount + 30) begin
      @(posedge clk); cyc++;
      #1;
      if (halted) break;
    end
    chk({tag, " R10 halt edge"}, cyc, 7 * ecount);
    chk({tag, " R3 accumulator"}, int'(acc_out), int'(eacc));
    for (int i = 0; i < 32; i++) begin
      dbg_addr = 5'(i);
      #1;
      chk($sformatf("%s R7 word %0d", tag, i), int'(dbg_data), int'(emem[i]));
    end
  endtask

  function automatic logic [7:0] peek_expected(input int a);
    return emem[a];
  endfunction

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'h1A2B3C4D));

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 halted", int'(halted), 0);
    chk("R1 acc", int'(acc_out), 0);
    chk("R1 pre_ready", int'(pre_ready), 1);

    // R11: worked example
    for (int i = 0; i < 32; i++) img[i] = 8'h00;
    img[0] = 8'h04; img[1] = 8'h45; img[2] = 8'h26; img[3] = 8'hFF;
    img[4] = 8'd24; img[5] = 8'd30;
    load_and_run("example");
    dbg_addr = 5'd6; #1;
    chk("R11 word 6", int'(dbg_data), 54);
    chk("R11 cycles", ecount * 7, 28);

    // R9 / R2: frozen after halt, preload ignored outside reset
    held = acc_out;
    @(negedge clk);
    pre_valid = 1'b1; pre_addr = 5'd6; pre_data = 8'hAA;
    #1;
    chk("R2 pre_ready low in run", int'(pre_ready), 0);
    repeat (20) @(negedge clk);
    pre_valid = 1'b0;
    dbg_addr = 5'd6; #1;
    chk("R2 word 6 untouched", int'(dbg_data), 54);
    chk("R9 still halted", int'(halted), 1);
    chk("R9 acc frozen", int'(acc_out), int'(held));

    // R4 R5 R6: ALU corner values
    for (int i = 0; i < 32; i++) img[i] = 8'hFF;
    img[0] = enc(3'b000, 16); img[1] = enc(3'b110, 16); img[2] = enc(3'b001, 20);
    img[3] = enc(3'b101, 17); img[4] = enc(3'b001, 21); img[5] = enc(3'b011, 18);
    img[6] = enc(3'b001, 22); img[7] = enc(3'b000, 19); img[8] = enc(3'b010, 23);
    img[9] = enc(3'b001, 24); img[10] = 8'hFF;
    img[16] = 8'h81; img[17] = 8'hC1; img[18] = 8'h5A; img[19] = 8'hF0; img[23] = 8'h20;
    load_and_run("alu");
    dbg_addr = 5'd20; #1; chk("R6 arithmetic right", int'(dbg_data), 8'hC0);
    dbg_addr = 5'd21; #1; chk("R6 left shift", int'(dbg_data), 8'h82);
    dbg_addr = 5'd22; #1; chk("R5 complement", int'(dbg_data), 8'hA5);
    dbg_addr = 5'd24; #1; chk("R4 wrapped sum", int'(dbg_data), 8'h10);

    // R8: branch not taken on negative accumulator
    for (int i = 0; i < 32; i++) img[i] = 8'hFF;
    img[0] = enc(3'b000, 20); img[1] = enc(3'b100, 5); img[2] = 8'hFF;
    img[5] = enc(3'b000, 21); img[20] = 8'h80; img[21] = 8'h11;
    load_and_run("R8 not taken");
    chk("R8 not taken acc", int'(acc_out), 8'h80);

    // R8: branch taken on non-negative accumulator
    img[20] = 8'h7F;
    load_and_run("R8 taken");
    chk("R8 taken acc", int'(acc_out), 8'h11);

    // R10: program counter wraps 31 -> 0
    for (int i = 0; i < 32; i++) img[i] = 8'h00;
    img[0] = enc(3'b100, 30); img[1] = 8'hFF;
    img[30] = enc(3'b000, 28); img[31] = enc(3'b001, 27); img[28] = 8'h90;
    load_and_run("R10 wrap");
    chk("R10 wrap count", ecount, 5);
    dbg_addr = 5'd27; #1; chk("R10 wrap store", int'(dbg_data), 8'h90);

    // Random programs: forward branches only, data in upper half
    for (int p = 0; p < 12; p++) begin
      for (int i = 0; i < 16; i++) img[i] = 8'hFF;
      for (int i = 16; i < 32; i++) img[i] = 8'($urandom);
      for (int i = 0; i < 8; i++) begin
        logic [2:0] op;
        op = 3'($urandom % 7);
        if (op == 3'b100) img[i] = enc(op, 5'(i + 1 + ($urandom % (8 - i))));
        else              img[i] = enc(op, 5'(16 + ($urandom % 16)));
      end
      load_and_run($sformatf("random%0d R4", p));
      chk($sformatf("random%0d R9 halted", p), int'(halted), 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule